// File: doc/BRIEF.md
# Transport packet sync acquisition

This block sits after an inner decoder. It takes a serial bit stream, qualified by a per-cycle valid strobe, and recovers the byte and packet framing of a transport stream. It packs the incoming bits into bytes, first bit in the MSB. While it has no framing, it compares every bit offset against the expected sync byte. When it finds a candidate, it re-times the byte boundary to that offset and waits one packet length to see whether the sync byte appears again. A saturating up/down counter, scored once per packet, turns the confirmed sync bytes into a lock indication that survives occasional corrupted sync bytes.

Two packet framings are supported, chosen by `frame_sel`:
- **Long framing:** the sync byte is 0x47. Its bitwise complement, which the stream carries on one packet in eight, is accepted in the same way.
- **Short framing:** the sync byte is 0x1D and has no complemented form.

A 2-bit input picks how many packets the lock counter must reach before lock is declared. A search-enable input freezes all sync processing, and the byte phase, so that a stream carrying no sync byte can still be packed into bytes.

Top module: `pkt_sync_acq`

## Requirements
- R1: Every 8 valid bits form one byte. The first-received bit lands in `byte_out[7]`. `byte_vld` pulses for one cycle, one clock after the completing bit, and never in a cycle whose input bit was not valid.
- R2: With `frame_sel`=0 a packet is `LEN_LONG` bytes (default 204). Both 0x47 and 0xB8 are valid sync values in byte 0.
- R3: With `frame_sel`=1 a packet is `LEN_SHORT` bytes (default 147) and only 0x1D is a valid sync value. The value 0xE2 never leads to lock.
- R4: While hunting with search enabled, a valid sync value that ends on any bit is emitted as a byte at once. The byte boundary is moved so that this byte becomes byte 0 of a packet.
- R5: A candidate is accepted only if a valid sync value arrives again as byte 0 exactly one packet later. Otherwise the hunt resumes.
- R6: After a candidate is accepted, each packet's byte 0 is scored. A valid sync adds 1 to the lock counter, saturating at the limit, and any other value subtracts 1. Acceptance sets the counter to 1. `locked` rises when the counter reaches the limit and falls only when it reaches 0, at which point the hunt restarts.
- R7: `hyst_sel` sets the limit to `HYST_BASE`·2^code packets: 00=16, 01=32, 10=64, 11=128 with the default base. Software is expected to program 01 (32 packets) after reset.
- R8: `pkt_start` is high together with `byte_vld` on byte 0 of a packet, and only while `locked` is (or becomes) high in that same cycle.
- R9: While `srch_en` is low, no sync value moves the byte phase, no packet is scored, and `locked` holds. Bytes and `pkt_start` continue at the held phase.
- R10: In the first cycles after reset, `byte_vld`, `pkt_start`, `locked` and `byte_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | `bit_in` carries a bit this cycle |
| frame_sel | input | 1 | 0: long framing, 1: short framing |
| hyst_sel | input | 2 | Lock counter limit code |
| srch_en | input | 1 | Enables sync search and packet scoring |
| byte_out | output | 8 | Last completed byte |
| byte_vld | output | 1 | `byte_out` is new this cycle |
| pkt_start | output | 1 | `byte_out` is byte 0 of a packet while locked |
| locked | output | 1 | Packet framing is locked |

## Verification
Clean packet streams are run in both framings, for every limit code and after every one of the eight possible leading bit offsets. Together these separate:
- the lock cycle, which must fall on the packet given by the limit;
- the phase search;
- acceptance of the complemented long sync byte on every eighth packet.

A stream whose second sync byte is missing shows whether a candidate is accepted without the repeat check. A stream with one isolated miss followed by a run of misses tells a saturating, hysteretic counter apart from one that drops lock early or late. A short-framing stream that carries only the complemented sync value confirms that the inverse is rejected. Runs with the search disabled check that a sync pattern at a foreign offset leaves the byte phase alone, and that repeated misses leave the lock alone.

// File: rtl/pkt_sync_pkg.sv
package pkt_sync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_TRACK  = 2'd2
  } acq_state_t;
endpackage

// File: rtl/psa_byte_packer.sv
module psa_byte_packer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bit_vld,
  input  logic         realign,
  output logic [W-1:0] win,
  output logic         byte_end
);
  localparam int CW = $clog2(W);

  logic [W-2:0] sr_q, sr_n;
  logic [CW-1:0] bcnt_q, bcnt_n;

  // sliding window of the last W bits, newest in the LSB
  assign win      = {sr_q, bit_in};
  assign byte_end = bit_vld && (realign || (bcnt_q == CW'(W-1)));

  always_comb begin
    sr_n   = sr_q;
    bcnt_n = bcnt_q;
    if (bit_vld) begin
      sr_n   = win[W-2:0];
      bcnt_n = byte_end ? '0 : bcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else begin
      sr_q   <= sr_n;
      bcnt_q <= bcnt_n;
    end
  end

  // R1: the bit phase moves only on valid bits
  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(bcnt_q));
  // R4: a realignment only happens on a valid bit
  assert_realign_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> bit_vld);
endmodule

// File: rtl/psa_sync_match.sv
module psa_sync_match #(
  parameter int          W          = 8,
  parameter logic [W-1:0] SYNC_LONG  = 8'h47,
  parameter logic [W-1:0] SYNC_SHORT = 8'h1D,
  parameter bit          ACCEPT_INV = 1'b1
) (
  input  logic [W-1:0] win,
  input  logic         frame_sel,
  output logic         hit
);
  logic long_hit;

  generate
    if (ACCEPT_INV) begin : g_inv
      assign long_hit = (win == SYNC_LONG) || (win == ~SYNC_LONG);
    end else begin : g_plain
      assign long_hit = (win == SYNC_LONG);
    end
  endgenerate

  assign hit = frame_sel ? (win == SYNC_SHORT) : long_hit;
endmodule

// File: rtl/psa_lock_ctr.sv
module psa_lock_ctr #(
  parameter int HYST_BASE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hyst_sel,
  input  logic       load,
  input  logic       inc,
  input  logic       dec,
  output logic       locked_nxt,
  output logic       locked,
  output logic       drop
);
  localparam int MAXL = HYST_BASE * 8;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          lock_q, lock_n;

  assign limit = CW'(HYST_BASE) << hyst_sel;

  always_comb begin
    cnt_n = cnt_q;
    if (load)      cnt_n = CW'(1);
    else if (inc)  cnt_n = (cnt_q >= limit) ? limit : cnt_q + CW'(1);
    else if (dec)  cnt_n = (cnt_q == '0) ? '0 : cnt_q - CW'(1);

    lock_n = lock_q;
    if (cnt_n >= limit)  lock_n = 1'b1;
    else if (cnt_n == '0) lock_n = 1'b0;
  end

  assign drop       = dec && (cnt_q <= CW'(1));
  assign locked_nxt = lock_n;
  assign locked     = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      lock_q <= lock_n;
    end
  end

  // R6: lock is gained only at the limit and lost only at zero
  assert_lock_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> (cnt_q >= limit));
  assert_unlock_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> (cnt_q == '0));
  assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec) && !(load && (inc || dec)));
endmodule

// File: rtl/pkt_sync_acq.sv
module pkt_sync_acq
  import pkt_sync_pkg::*;
#(
  parameter int         LEN_LONG   = 204,
  parameter int         LEN_SHORT  = 147,
  parameter logic [7:0] SYNC_LONG  = 8'h47,
  parameter logic [7:0] SYNC_SHORT = 8'h1D,
  parameter int         HYST_BASE  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_vld,
  input  logic       frame_sel,
  input  logic [1:0] hyst_sel,
  input  logic       srch_en,
  output logic [7:0] byte_out,
  output logic       byte_vld,
  output logic       pkt_start,
  output logic       locked
);
  localparam int LMAX = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT;
  localparam int PW   = $clog2(LMAX);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acq_state_t    st_q, st_n;
  logic [PW-1:0] pidx_q, pidx_n, last_idx;
  logic [7:0]    win, byte_q, byte_n;
  logic          vld_q, vld_n, ps_q, ps_n;
  logic          hit, realign, byte_end, slot0, chk;
  logic          load, inc, dec, drop, locked_nxt, lock_r;

  psa_byte_packer #(.W(8)) u_packer (
    .clk(clk), .rst_n(rst_int_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .realign(realign), .win(win), .byte_end(byte_end)
  );

  psa_sync_match #(.W(8), .SYNC_LONG(SYNC_LONG), .SYNC_SHORT(SYNC_SHORT),
                   .ACCEPT_INV(1'b1)) u_match (
    .win(win), .frame_sel(frame_sel), .hit(hit)
  );

  psa_lock_ctr #(.HYST_BASE(HYST_BASE)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .hyst_sel(hyst_sel), .load(load),
    .inc(inc), .dec(dec), .locked_nxt(locked_nxt), .locked(lock_r),
    .drop(drop)
  );

  assign last_idx = frame_sel ? PW'(LEN_SHORT - 1) : PW'(LEN_LONG - 1);
  assign realign  = srch_en && (st_q == ST_HUNT) && bit_vld && hit;
  assign slot0    = (st_q != ST_HUNT) && (pidx_q == '0);
  assign chk      = srch_en && byte_end && slot0;
  assign load     = (st_q == ST_VERIFY) && chk && hit;
  assign inc      = (st_q == ST_TRACK) && chk && hit;
  assign dec      = (st_q == ST_TRACK) && chk && !hit;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_HUNT:   if (realign) st_n = ST_VERIFY;
      ST_VERIFY: if (chk)     st_n = hit ? ST_TRACK : ST_HUNT;
      ST_TRACK:  if (drop)    st_n = ST_HUNT;
      default:                st_n = ST_HUNT;
    endcase

    pidx_n = pidx_q;
    if (realign)       pidx_n = PW'(1);
    else if (byte_end) pidx_n = (pidx_q >= last_idx) ? '0 : pidx_q + PW'(1);

    vld_n  = byte_end;
    byte_n = byte_end ? win : byte_q;
    ps_n   = byte_end && slot0 && locked_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_HUNT;
      pidx_q <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      ps_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      pidx_q <= pidx_n;
      byte_q <= byte_n;
      vld_q  <= vld_n;
      ps_q   <= ps_n;
    end
  end

  assign byte_out  = byte_q;
  assign byte_vld  = vld_q;
  assign pkt_start = ps_q;
  assign locked    = lock_r;

  // R1: a byte only follows a valid input bit
  assert_byte_after_bit_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    byte_vld |-> $past(bit_vld));
  // R8: packet start only with a byte and only under lock
  assert_start_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    pkt_start |-> (locked && byte_vld));
  // R9: with the search off the acquisition state and lock hold
  assert_state_frozen_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !srch_en |=> (st_q == $past(st_q)));
  assert_lock_frozen_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !srch_en |=> $stable(locked));
  // R6: lock is never held while hunting
  assert_no_lock_in_hunt_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_HUNT) |-> !locked);
endmodule

// File: tb/pkt_sync_acq_tb_top.sv
module pkt_sync_acq_tb_top;
  localparam int LA = 12;
  localparam int LB = 9;
  localparam int HB = 2;
  localparam time CYC = 20ns;

  logic       clk = 1'b0;
  logic       rst_n, bit_in, bit_vld, frame_sel, srch_en;
  logic [1:0] hyst_sel;
  logic [7:0] byte_out;
  logic       byte_vld, pkt_start, locked;

  int nchk = 0;
  int nfail = 0;
  int nbits = 0;
  logic [7:0] s_byte;
  logic       s_vld, s_ps, s_lock;

  always #(CYC/2) clk = ~clk;

  pkt_sync_acq #(.LEN_LONG(LA), .LEN_SHORT(LB), .HYST_BASE(HB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .frame_sel(frame_sel), .hyst_sel(hyst_sel), .srch_en(srch_en),
    .byte_out(byte_out), .byte_vld(byte_vld), .pkt_start(pkt_start),
    .locked(locked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sample();
    s_byte = byte_out; s_vld = byte_vld; s_ps = pkt_start; s_lock = locked;
  endtask

  // drive one bit at a falling edge, sample results at the next falling edge
  task automatic sb(input logic b);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    sample();
    nbits++;
    if (nbits % 5 == 0) begin
      bit_vld = 1'b0; bit_in = 1'b1;
      @(negedge clk);
      check("R1 idle cycle gives no byte", {31'd0, byte_vld}, 32'd0);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int j = 7; j >= 0; j--) sb(v[j]);
  endtask

  task automatic do_reset(input logic fm, input logic [1:0] code, input logic en);
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    frame_sel = fm; hyst_sel = code; srch_en = en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset byte_vld", {31'd0, byte_vld}, 32'd0);
    check("R10 reset pkt_start", {31'd0, pkt_start}, 32'd0);
    check("R10 reset locked", {31'd0, locked}, 32'd0);
    check("R10 reset byte_out", {24'd0, byte_out}, 32'd0);
  endtask

  function automatic logic [7:0] sync_of(input logic fm, input int k, input logic inv);
    if (fm) return inv ? 8'hE2 : 8'h1D;
    return ((k % 8) == 7) ? 8'hB8 : 8'h47;
  endfunction

  // one packet per k; byte 0 carries sync when hit[k], lk[k] is the expected lock
  task automatic play(input logic fm, input int k0, input int npk, input logic [31:0] hit,
                      input logic [31:0] lk, input logic inv, input string tag);
    int plen;
    plen = fm ? LB : LA;
    for (int k = 0; k < npk; k++) begin
      for (int i = 0; i < plen; i++) begin
        logic [7:0] v;
        v = 8'h00;
        if (i == 0 && hit[k]) v = sync_of(fm, k0 + k, inv);
        send_byte(v);
        check({tag, " R1 byte_vld"}, {31'd0, s_vld}, 32'd1);
        check({tag, " R1 byte_out"}, {24'd0, s_byte}, {24'd0, v});
        check({tag, " R8 pkt_start"}, {31'd0, s_ps}, {31'd0, (i == 0) && lk[k]});
        check({tag, " R6 locked"}, {31'd0, s_lock}, {31'd0, lk[k]});
      end
    end
  endtask

  initial begin
    #(CYC * 190000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R10 then R1 packing before any sync
    do_reset(1'b0, 2'd0, 1'b1);
    send_byte(8'h5A);
    check("R1 first byte valid", {31'd0, s_vld}, 32'd1);
    check("R1 first byte MSB first", {24'd0, s_byte}, 32'h5A);
    send_byte(8'hC3);
    check("R1 second byte", {24'd0, s_byte}, 32'hC3);
    check("R8 no start unlocked", {31'd0, s_ps}, 32'd0);

    // R2 R3 R4 R7: all framings, limit codes and leading bit offsets
    for (int fm = 0; fm < 2; fm++)
      for (int code = 0; code < 4; code++)
        for (int g = 0; g < 8; g++) begin
          int lim;
          logic [31:0] lk;
          lim = HB << code;
          lk = '0;
          for (int k = 0; k < 32; k++) lk[k] = (k >= lim);
          do_reset(fm[0], code[1:0], 1'b1);
          repeat (g) sb(1'b0);
          play(fm[0], 0, lim + 2, '1, lk, 1'b0,
               fm ? "R3 R4 R7 short acq" : "R2 R4 R7 long acq");
        end

    // R5: second sync missing, candidate rejected, lock one packet later
    do_reset(1'b0, 2'd0, 1'b1);
    play(1'b0, 0, 6, 32'b111101, 32'b110000, 1'b0, "R5 verify");

    // R6: hysteresis with saturation, drop at zero, reacquire
    do_reset(1'b0, 2'd1, 1'b1);
    repeat (5) sb(1'b0);
    play(1'b0, 0, 17, 32'h1F85F, 32'h183F0, 1'b0, "R6 hysteresis");

    // R3: complemented short sync never locks
    do_reset(1'b1, 2'd0, 1'b1);
    play(1'b1, 0, 6, '1, '0, 1'b1, "R3 reject inverse");

    // R9: phase held with search off
    do_reset(1'b0, 2'd0, 1'b0);
    repeat (3) sb(1'b0);
    for (int j = 7; j >= 3; j--) sb(sync_of(1'b0, 0, 1'b0)[j]);
    check("R9 held phase byte valid", {31'd0, s_vld}, 32'd1);
    check("R9 held phase byte", {24'd0, s_byte}, 32'h08);
    for (int j = 2; j >= 0; j--) sb(sync_of(1'b0, 0, 1'b0)[j]);
    check("R9 no realign at sync end", {31'd0, s_vld}, 32'd0);
    repeat (5) sb(1'b0);
    check("R9 held phase second byte", {24'd0, s_byte}, 32'hE0);
    check("R9 no lock while off", {31'd0, s_lock}, 32'd0);

    // R9: lock frozen through misses while off, scoring resumes when on
    do_reset(1'b0, 2'd0, 1'b1);
    repeat (2) sb(1'b0);
    play(1'b0, 0, 3, '1, 32'b100, 1'b0, "R9 pre");
    srch_en = 1'b0;
    play(1'b0, 3, 4, '0, 32'b1111, 1'b0, "R9 frozen");
    srch_en = 1'b1;
    play(1'b0, 7, 2, '0, 32'b01, 1'b0, "R9 resume");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule